// File: doc/BRIEF.md
# Serial Flash Status and Write Guard

This block holds the status byte of a serial flash device and decides, cycle by cycle, whether an array write to a given sector may go ahead. It watches several event strobes from the rest of the device:

- the write-enable and write-disable command strobes;
- the start and completion events of array programming;
- the start and completion events of SRAM/program-buffer transfers.

It also reads the level of the active-low write-protect pin. From these it keeps three flags: busy, transfer and write-enable.

A 4-bit range code and a direction bit choose a protected span of sectors. The span is counted in blocks of a fixed sector count, from either the bottom or the top of the array. The write-allowed output combines the flags with a range check on the target sector number.

The status byte feeds the shifter that answers a status-read command. The write-allowed flag gates the programming engine. Neither the programming engine nor the serial shifting is part of this block.

Top module: `sflash_status_guard`

## Requirements
- R1: Status bit 7 (busy) reads 1 from the clock edge after `prog_start` until the edge after `prog_done`. When both strobes arrive in one cycle, the start wins.
- R2: Status bit 6 (transfer) reads 1 from the edge after `xfer_start` until the edge after `xfer_done`. When both arrive in one cycle, the start wins.
- R3: Whenever status bit 6 reads 1, status bit 7 also reads 1.
- R4: Status bit 4 (write enable) is set on the edge after `wr_enable` while `wp_n` is high. It is cleared on the edge after `wr_disable`. When both strobes arrive in one cycle, the disable wins.
- R5: While `rst_n` is low the status byte reads 0x00 and `write_ok` reads 0. An enable strobe given during reset leaves bit 4 at 0 after reset is released.
- R6: An enable strobe taken while `wp_n` is low leaves status bit 4 at 0 on the next edge, even if it was 1 before.
- R7: Range code 0000 protects no sector. Range code 1111 protects every sector.
- R8: With `prot_top` = 0, a range code n from 1 to 14 protects sectors 0 through 32·n−1 (default granularity of 32 sectors).
- R9: With `prot_top` = 1, a range code n from 1 to 14 protects the highest 32·n sectors, up to and including the last sector (511 by default).
- R10: `write_ok` is 1 exactly when bit 4 is 1, bit 7 is 0 and `sector` is unprotected. It follows `sector`, `prot_code` and `prot_top` in the same cycle.
- R11: Status bits 5, 3, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_enable | input | 1 | Write-enable command strobe |
| wr_disable | input | 1 | Write-disable command strobe |
| prog_start | input | 1 | Array programming begins |
| prog_done | input | 1 | Array programming completes |
| xfer_start | input | 1 | SRAM/program-buffer transfer begins |
| xfer_done | input | 1 | SRAM/program-buffer transfer completes |
| wp_n | input | 1 | Write-protect pin, active low |
| prot_code | input | CODE_W (4) | Protected-range size code |
| prot_top | input | 1 | 0: range counted from sector 0; 1: from the last sector |
| sector | input | SECTOR_W (9) | Target sector of the requested write |
| status_byte | output | 8 | Status byte for the status-read command |
| write_ok | output | 1 | Array write to `sector` is permitted |

## Verification
Every strobe passes through one flag register, so its effect on the status byte is due one rising edge after the strobe is sampled. The bench drives strobes on the falling edge and reads the byte at the next falling edge, one full edge later. The range decision and `write_ok` are combinational from the registered flags and the range inputs. Those checks therefore read the output one nanosecond after changing the inputs, with no clock edge in between. The reset checks sample while reset is still held and again right after its release, with no edge in between.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
   localparam int STATUS_W   = 8;
   localparam int BIT_BUSY   = 7;
   localparam int BIT_XFER   = 6;
   localparam int BIT_WREN   = 4;

   typedef struct packed {
      logic busy;
      logic xfer;
      logic wren;
   } sfg_flags_t;

   function automatic logic [STATUS_W-1:0] pack_status(sfg_flags_t f);
      logic [STATUS_W-1:0] s;
      s = '0;
      s[BIT_BUSY] = f.busy;
      s[BIT_XFER] = f.xfer;
      s[BIT_WREN] = f.wren;
      return s;
   endfunction
endpackage

// File: rtl/sfg_activity_track.sv
module sfg_activity_track (
   input  logic clk,
   input  logic rst_n,
   input  logic start_ev,
   input  logic done_ev,
   output logic active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        active <= 1'b0;
      else if (start_ev) active <= 1'b1;
      else if (done_ev)  active <= 1'b0;
   end

   AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> active); // R1
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ev && !start_ev) |=> !active); // R2
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_ev && !start_ev) |=> $stable(active)); // R1
endmodule

// File: rtl/sfg_enable_latch.sv
module sfg_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en_cmd,
   input  logic dis_cmd,
   input  logic wp_n,
   output logic wren
);
   logic nxt;

   always_comb begin
      nxt = wren;
      if (en_cmd)  nxt = wp_n;
      if (dis_cmd) nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wren <= 1'b0;
      else        wren <= nxt;
   end

   AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> !wren); // R4
   AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cmd && wp_n && !dis_cmd) |=> wren); // R4
   AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cmd && !wp_n) |=> !wren); // R6
endmodule

// File: rtl/sfg_range_map.sv
module sfg_range_map #(
   parameter int SECTOR_W = 9,
   parameter int CODE_W   = 4,
   parameter int GRAN     = 32
) (
   input  logic [CODE_W-1:0]   code,
   input  logic                from_top,
   input  logic [SECTOR_W-1:0] sector,
   output logic                hit
);
   localparam int SPAN_W    = SECTOR_W + 1;
   localparam int NSECT     = 1 << SECTOR_W;
   localparam int MAX_CODE  = (1 << CODE_W) - 1;
   localparam bit GRAN_POW2 = (GRAN > 0) && ((GRAN & (GRAN - 1)) == 0);
   localparam int GRAN_LOG  = $clog2(GRAN);

   if ((MAX_CODE - 1) * GRAN >= NSECT) begin : g_bad_span
      $error("sfg_range_map: largest partial span exceeds sector count");
   end
   if (GRAN < 1) begin : g_bad_gran
      $error("sfg_range_map: granularity must be positive");
   end

   logic [SPAN_W-1:0] span;
   logic [SPAN_W-1:0] top_base;
   logic [SPAN_W-1:0] sec_w;

   if (GRAN_POW2) begin : g_shift
      assign span = SPAN_W'(code) << GRAN_LOG;
   end else begin : g_mult
      assign span = SPAN_W'(code) * SPAN_W'(GRAN);
   end

   assign top_base = SPAN_W'(NSECT) - span;
   assign sec_w    = {1'b0, sector};

   always_comb begin
      if (code == '0)                   hit = 1'b0;
      else if (code == CODE_W'(MAX_CODE)) hit = 1'b1;
      else if (from_top)                hit = (sec_w >= top_base);
      else                              hit = (sec_w < span);
   end
endmodule

// File: rtl/sflash_status_guard.sv
module sflash_status_guard #(
   parameter int SECTOR_W = 9,
   parameter int CODE_W   = 4,
   parameter int GRAN     = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_enable,
   input  logic                wr_disable,
   input  logic                prog_start,
   input  logic                prog_done,
   input  logic                xfer_start,
   input  logic                xfer_done,
   input  logic                wp_n,
   input  logic [CODE_W-1:0]   prot_code,
   input  logic                prot_top,
   input  logic [SECTOR_W-1:0] sector,
   output logic [7:0]          status_byte,
   output logic                write_ok
);
   import sfg_pkg::*;

   if (SECTOR_W < 2 || SECTOR_W > 24) begin : g_bad_sw
      $error("sflash_status_guard: SECTOR_W out of range");
   end
   if (CODE_W < 2) begin : g_bad_cw
      $error("sflash_status_guard: CODE_W too small");
   end

   logic       prog_act;
   logic       xfer_act;
   logic       wren;
   logic       prot_hit;
   sfg_flags_t flags;
   logic [STATUS_W-1:0] st;

   sfg_activity_track u_prog (
      .clk(clk), .rst_n(rst_n),
      .start_ev(prog_start), .done_ev(prog_done), .active(prog_act));

   sfg_activity_track u_xfer (
      .clk(clk), .rst_n(rst_n),
      .start_ev(xfer_start), .done_ev(xfer_done), .active(xfer_act));

   sfg_enable_latch u_wren (
      .clk(clk), .rst_n(rst_n),
      .en_cmd(wr_enable), .dis_cmd(wr_disable), .wp_n(wp_n), .wren(wren));

   sfg_range_map #(.SECTOR_W(SECTOR_W), .CODE_W(CODE_W), .GRAN(GRAN)) u_range (
      .code(prot_code), .from_top(prot_top), .sector(sector), .hit(prot_hit));

   always_comb begin
      flags.busy = prog_act | xfer_act;
      flags.xfer = xfer_act;
      flags.wren = wren;
      st = pack_status(flags);
   end

   for (genvar b = 0; b < STATUS_W; b++) begin : g_status
      assign status_byte[b] = st[b];
   end

   assign write_ok = flags.wren & ~flags.busy & ~prot_hit;

   AST_BUSY_COVERS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[BIT_XFER] |-> status_byte[BIT_BUSY]); // R3
   AST_WRITE_NEEDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      write_ok |-> (status_byte[BIT_WREN] && !status_byte[BIT_BUSY])); // R10
   AST_FULL_CODE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_code == '1) |-> !write_ok); // R7
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[5] == 1'b0) && (status_byte[3:0] == 4'b0)); // R11
endmodule

// File: tb/sflash_status_guard_tb.sv
module sflash_status_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_enable = 0, wr_disable = 0;
   logic       prog_start = 0, prog_done = 0;
   logic       xfer_start = 0, xfer_done = 0;
   logic       wp_n = 1'b1;
   logic [3:0] prot_code = 4'd0;
   logic       prot_top = 1'b0;
   logic [8:0] sector = 9'd0;
   logic [7:0] status_byte;
   logic       write_ok;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   sflash_status_guard u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_enable(wr_enable), .wr_disable(wr_disable),
      .prog_start(prog_start), .prog_done(prog_done),
      .xfer_start(xfer_start), .xfer_done(xfer_done),
      .wp_n(wp_n), .prot_code(prot_code), .prot_top(prot_top),
      .sector(sector), .status_byte(status_byte), .write_ok(write_ok));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_prot(input int code, input logic top, input int sec);
      int span;
      if (code == 0)  return 1'b0;
      if (code == 15) return 1'b1;
      span = code * 32;
      if (top) return sec >= (512 - span);
      return sec < span;
   endfunction

   // drive one strobe cycle: inputs change at negedge, posedge captures,
   // next negedge is where the result is sampled
   task automatic cyc();
      @(negedge clk);
      wr_enable = 0; wr_disable = 0; prog_start = 0; prog_done = 0;
      xfer_start = 0; xfer_done = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R5 status in reset", status_byte, 8'h00);
      chk("R5 write_ok in reset", write_ok, 1'b0);
      wr_enable = 1;
      @(negedge clk);
      chk("R5 reset wins over enable", status_byte, 8'h00);
      wr_enable = 0;
      rst_n = 1'b1;
      #1 chk("R5 status after release", status_byte, 8'h00);
   endtask

   task automatic t_enable();
      wr_enable = 1; cyc();
      chk("R4 enable sets bit4", status_byte, 8'h10);
      chk("R11 reserved bits zero", status_byte & 8'h2F, 8'h00);
      wr_disable = 1; cyc();
      chk("R4 disable clears bit4", status_byte, 8'h00);
      wr_enable = 1; cyc();
      wr_enable = 1; wr_disable = 1; cyc();
      chk("R4 disable wins over enable", status_byte, 8'h00);
   endtask

   task automatic t_wp();
      wp_n = 0; wr_enable = 1; cyc();
      chk("R6 enable with pin low", status_byte[4], 1'b0);
      wp_n = 1; wr_enable = 1; cyc();
      chk("R6 enable with pin high", status_byte[4], 1'b1);
      wp_n = 0; wr_enable = 1; cyc();
      chk("R6 enable with pin low drops flag", status_byte[4], 1'b0);
      wp_n = 1;
   endtask

   task automatic t_prog();
      prog_start = 1; cyc();
      chk("R1 busy after start", status_byte[7], 1'b1);
      cyc();
      chk("R1 busy holds", status_byte[7], 1'b1);
      prog_start = 1; prog_done = 1; cyc();
      chk("R1 start wins over done", status_byte[7], 1'b1);
      prog_done = 1; cyc();
      chk("R1 busy clears after done", status_byte[7], 1'b0);
   endtask

   task automatic t_xfer();
      xfer_start = 1; cyc();
      chk("R2 transfer flag set", status_byte[6], 1'b1);
      chk("R3 busy covers transfer", status_byte[7], 1'b1);
      xfer_start = 1; xfer_done = 1; cyc();
      chk("R2 start wins over done", status_byte[6], 1'b1);
      xfer_done = 1; cyc();
      chk("R2 transfer flag clears", status_byte & 8'hC0, 8'h00);
   endtask

   task automatic t_ranges();
      // write enable must be on and not busy so write_ok exposes protection
      wr_enable = 1; cyc();
      for (int c = 0; c < 16; c++) begin
         for (int t = 0; t < 2; t++) begin
            int edges [4];
            edges[0] = 0; edges[1] = 511;
            edges[2] = (c * 32) - 1; edges[3] = 512 - c * 32;
            for (int e = 0; e < 4; e++) begin
               if (edges[e] >= 0 && edges[e] <= 511) begin
                  prot_code = 4'(c); prot_top = t[0]; sector = 9'(edges[e]);
                  #1;
                  if (c == 0 || c == 15)
                     chk("R7 extreme codes", write_ok, !exp_prot(c, t[0], edges[e]));
                  else if (t == 0)
                     chk("R8 bottom range", write_ok, !exp_prot(c, 1'b0, edges[e]));
                  else
                     chk("R9 top range", write_ok, !exp_prot(c, 1'b1, edges[e]));
               end
            end
         end
      end
      prot_code = 4'd5; prot_top = 1'b0; sector = 9'd160; #1;
      chk("R8 first sector past span", write_ok, 1'b1);
      sector = 9'd159; #1;
      chk("R8 last protected sector", write_ok, 1'b0);
      prot_top = 1'b1; sector = 9'd351; #1;
      chk("R9 sector below top span", write_ok, 1'b1);
   endtask

   task automatic t_write_ok();
      prot_code = 4'd0; sector = 9'd100;
      cyc();
      chk("R10 enabled idle allows", write_ok, 1'b1);
      prog_start = 1; cyc();
      chk("R10 busy blocks write", write_ok, 1'b0);
      prog_done = 1; cyc();
      chk("R10 done reopens write", write_ok, 1'b1);
      wr_disable = 1; cyc();
      chk("R10 disabled blocks write", write_ok, 1'b0);
   endtask

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_enable();
      t_wp();
      t_prog();
      t_xfer();
      t_ranges();
      t_write_ok();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule